// File: doc/BRIEF.md
# Buffered Synchronous Serial Shift Engine

This block moves 8-bit words over a clocked serial link as the clock master. Software-side logic writes a word into a transmit buffer and reads finished words from a receive buffer. A single shift register sits between the two buffers. Each telegram starts by copying the transmit buffer into the shift register. The block then produces eight shift-clock periods, most significant bit first, and shifts the serial input in at the same time. At the end it hands the received word to the receive buffer.

The link runs either with separate data-in and data-out wires, or with one bidirectional data wire whose output enable follows the transfer direction. The shift clock is the system clock divided by a parameter. It rests at its idle level whenever the engine is stopped or waiting for a buffer.

The engine stalls by itself when the buffer it needs is not ready: in transmit mode it waits for a written word, and in receive mode it holds a finished word until the previous one has been read. Raising the halt input in mid-word stops the clock at once and drops the partial word into the receive buffer.

Top module: `sse_engine`

## Requirements
- R1: After reset, `sc` sits at its idle level, `active`, `ready` and `irq` are 0, `sd_out` is 1 and `rx_data` is 0.
- R2: A telegram is 8 bits, sent most significant bit first. The shift register is loaded from the transmit buffer in the cycle the telegram starts, and `sd_out` shows the bit currently being sent.
- R3: With `edge_sel`=0, `sc` idles high, data changes on the falling edge and input is sampled on the rising edge. With `edge_sel`=1 the levels and edges are swapped.
- R4: In transmit mode (`dir_tx`=1) no telegram starts while the transmit buffer is empty; `sc` stays idle. `ready` shows whether the transmit buffer holds a word.
- R5: In receive mode (`dir_tx`=0), clearing `halt` starts shift clocks in the next cycle. Each finished word is copied to `rx_data`, and `ready` (the receive-buffer-full flag) goes to 1.
- R6: In receive mode, a finished word that arrives while the receive buffer is still unread is held. The clock stays idle and `rx_data` keeps its value until `rx_rd`, after which the held word is copied.
- R7: Raising `halt` during a telegram returns `sc` to idle and clears `active` at the next edge. At that edge the shift register contents (a partial word, newest bit in bit 0) are copied to `rx_data`.
- R8: `active` is 1 from the cycle after a telegram starts until its last bit has been sampled and shifted.
- R9: `irq` is a one-cycle pulse gated by `irq_en`. With `irq_on_end`=1 it fires when a telegram completes. With `irq_on_end`=0 it fires when the transmit buffer is emptied (transmit mode) or a word enters the receive buffer (receive mode).
- R10: `sd_oe` is 1 in three-wire mode (`three_wire`=1). In two-wire mode it equals `dir_tx`.
- R11: Each bit lasts 2*`DIV_HALF` system clocks: `DIV_HALF` at the leading level, then `DIV_HALF` at the idle level. Back-to-back telegrams are separated by one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt | input | 1 | 1 = engine deactivated, 0 = run |
| dir_tx | input | 1 | 1 = transmit mode, 0 = receive mode |
| edge_sel | input | 1 | Shift clock edge selection (R3) |
| three_wire | input | 1 | 1 = separate data wires, 0 = shared data wire |
| irq_en | input | 1 | Interrupt enable |
| irq_on_end | input | 1 | Interrupt source: 1 = telegram end, 0 = buffer status |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_din | input | 8 | Transmit buffer write data |
| rx_rd | input | 1 | Read strobe, clears the receive-buffer-full flag |
| sd_in | input | 1 | Serial data input |
| sc | output | 1 | Shift clock |
| sd_out | output | 1 | Serial data output |
| sd_oe | output | 1 | Output enable for a shared data pin |
| ready | output | 1 | Buffer flag of the current direction |
| active | output | 1 | Telegram in progress |
| irq | output | 1 | Interrupt pulse |
| rx_data | output | 8 | Receive buffer contents |

## Verification
A transmit run feeds `sd_out` back into `sd_in` with two different words and both edge settings. Because each word must return intact, this separates a wrong bit order or a wrong sampling edge from a correct one. Receive runs use a varying input pattern and leave words unread, which shows the stall-and-hold behaviour apart from an engine that silently overwrites. A halt after exactly three bits, with an all-ones input and an all-zero transmit word, must give 0x07; this pins down both the partial-word latch and the clock stop. A behavioural model compared on every clock additionally catches any one-cycle shift in clock phase, interrupt timing or flag timing.

// File: rtl/sse_pkg.sv
// Shared types for the serial shift engine.
package sse_pkg;
    // Engine sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting to start a telegram
        ST_SHIFT = 2'd1,   // shift clock running
        ST_HOLD  = 2'd2    // finished word waiting for a free receive buffer
    } sse_state_t;
endpackage

// File: rtl/sse_divider.sv
// Half-period tick generator for the shift clock.
// Assumes DIV_HALF >= 2. While `run` is low the counter and the phase are held at zero,
// so each telegram starts at the beginning of a leading half.
module sse_divider #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick,
    output logic half
);
    localparam int CW = $clog2(DIV_HALF + 1);

    logic [CW-1:0] divcnt;

    assign tick = run && (divcnt == CW'(DIV_HALF - 1));

    // Count system clocks within one half period of the shift clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) divcnt <= '0;
        else if (tick)      divcnt <= '0;
        else                divcnt <= divcnt + 1'b1;
    end

    // Track which half of the bit period is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) half <= 1'b0;
        else if (tick)      half <= ~half;
    end

    assert_div_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        divcnt < CW'(DIV_HALF));
endmodule

// File: rtl/sse_buffers.sv
// Transmit and receive holding registers with their full flags.
// A write sets the transmit flag even if a take happens in the same cycle;
// a put sets the receive flag even if a read happens in the same cycle.
module sse_buffers #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_din,
    input  logic              tx_take,
    input  logic              rx_rd,
    input  logic              rx_put,
    input  logic [WORD_W-1:0] rx_din,
    output logic [WORD_W-1:0] tx_buf,
    output logic              tx_full,
    output logic [WORD_W-1:0] rx_buf,
    output logic              rx_full
);
    // Transmit buffer: filled by the writer, emptied when a telegram loads it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf  <= '0;
            tx_full <= 1'b0;
        end else if (tx_wr) begin
            tx_buf  <= tx_din;
            tx_full <= 1'b1;
        end else if (tx_take) begin
            tx_full <= 1'b0;
        end
    end

    // Receive buffer: filled by the engine, freed by the reader.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf  <= '0;
            rx_full <= 1'b0;
        end else if (rx_put) begin
            rx_buf  <= rx_din;
            rx_full <= 1'b1;
        end else if (rx_rd) begin
            rx_full <= 1'b0;
        end
    end

    assert_rx_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_put |=> rx_full);
endmodule

// File: rtl/sse_engine.sv
// Buffered synchronous serial shift engine, clock master only.
// Sequences 8-bit MSB-first telegrams between a transmit buffer and a receive buffer,
// stalling when the buffer of the active direction is not ready. Assumes dir_tx and
// edge_sel are changed only while the engine is idle.
module sse_engine #(
    parameter int WORD_W   = 8,
    parameter int DIV_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              dir_tx,
    input  logic              edge_sel,
    input  logic              three_wire,
    input  logic              irq_en,
    input  logic              irq_on_end,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_din,
    input  logic              rx_rd,
    input  logic              sd_in,
    output logic              sc,
    output logic              sd_out,
    output logic              sd_oe,
    output logic              ready,
    output logic              active,
    output logic              irq,
    output logic [WORD_W-1:0] rx_data
);
    import sse_pkg::*;

    localparam int BW = $clog2(WORD_W);

    sse_state_t        state;
    logic [WORD_W-1:0] sreg;
    logic [BW-1:0]     bitcnt;
    logic              smp;
    logic              tick;
    logic              half;
    logic [WORD_W-1:0] tx_buf;
    logic              tx_full;
    logic              rx_full;
    logic              start;
    logic              last;
    logic              abort;
    logic              rx_put;
    logic [WORD_W-1:0] rx_din;
    logic [WORD_W-1:0] word;
    logic              buf_evt;
    logic              end_evt;

    sse_divider #(.DIV_HALF(DIV_HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_SHIFT),
        .tick  (tick),
        .half  (half)
    );

    sse_buffers #(.WORD_W(WORD_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_wr   (tx_wr),
        .tx_din  (tx_din),
        .tx_take (start && dir_tx),
        .rx_rd   (rx_rd),
        .rx_put  (rx_put),
        .rx_din  (rx_din),
        .tx_buf  (tx_buf),
        .tx_full (tx_full),
        .rx_buf  (rx_data),
        .rx_full (rx_full)
    );

    // Decode the sequencing events of this cycle.
    always_comb begin
        word    = {sreg[WORD_W-2:0], smp};
        abort   = halt && (state != ST_IDLE);
        start   = (state == ST_IDLE) && !halt && (dir_tx ? tx_full : 1'b1);
        last    = (state == ST_SHIFT) && tick && half && (bitcnt == BW'(WORD_W - 1));
        end_evt = last && !abort;
        rx_put  = abort
                || (end_evt && (dir_tx || !rx_full))
                || ((state == ST_HOLD) && !rx_full && !halt);
        rx_din  = (end_evt) ? word : sreg;
        buf_evt = dir_tx ? start : (rx_put && !abort);
    end

    // Advance the telegram state machine.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (start) state <= ST_SHIFT;
                ST_SHIFT: if (last)  state <= (!dir_tx && rx_full) ? ST_HOLD : ST_IDLE;
                ST_HOLD:  if (!rx_full) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Load, sample and shift the data path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg   <= '0;
            smp    <= 1'b0;
            bitcnt <= '0;
        end else if (start) begin
            sreg   <= tx_buf;
            bitcnt <= '0;
        end else if ((state == ST_SHIFT) && tick && !abort) begin
            if (!half) begin
                smp <= sd_in;
            end else begin
                sreg   <= word;
                bitcnt <= bitcnt + 1'b1;
            end
        end
    end

    // Register the interrupt pulse from the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= irq_en && (irq_on_end ? end_evt : buf_evt);
    end

    // Drive the pins and status flags.
    always_comb begin
        active = (state == ST_SHIFT);
        sc     = active ? (half ^ edge_sel) : ~edge_sel;
        sd_out = active ? sreg[WORD_W-1] : 1'b1;
        sd_oe  = three_wire ? 1'b1 : dir_tx;
        ready  = dir_tx ? tx_full : rx_full;
    end

    assert_halt_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && active) |=> !active);

    assert_tx_needs_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(active) && dir_tx) |-> $past(tx_full));

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_hold_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HOLD) && rx_full && !halt) |=> $stable(rx_data));

    assert_active_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !halt && !last) |=> active);
endmodule

// File: tb/sse_engine_tb.sv
module sse_engine_tb;
    localparam int D = 2;
    localparam int TEL = 16 * D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt = 1'b1, dir_tx = 1'b1, edge_sel = 1'b0, three_wire = 1'b1;
    logic irq_en = 1'b1, irq_on_end = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0, sd_in = 1'b0;
    logic [7:0] tx_din = 8'h00;
    logic sc, sd_out, sd_oe, ready, active, irq;
    logic [7:0] rx_data;

    always #10 clk = ~clk;

    sse_engine #(.WORD_W(8), .DIV_HALF(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .halt(halt), .dir_tx(dir_tx), .edge_sel(edge_sel),
        .three_wire(three_wire), .irq_en(irq_en), .irq_on_end(irq_on_end),
        .tx_wr(tx_wr), .tx_din(tx_din), .rx_rd(rx_rd), .sd_in(sd_in),
        .sc(sc), .sd_out(sd_out), .sd_oe(sd_oe), .ready(ready), .active(active),
        .irq(irq), .rx_data(rx_data)
    );

    int n_chk = 0, n_fail = 0, cyc = 0, irq_cnt = 0;
    bit loop = 1'b0, done = 1'b0;
    logic [7:0] pat = 8'h5B;

    // Reference model state: 0 idle, 1 shifting, 2 holding.
    int m_st = 0, m_t = 0;
    logic [7:0] m_sreg = 0, m_txb = 0, m_rxb = 0;
    logic m_smp = 0, m_txf = 0, m_rxf = 0, m_irq = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic model_step();
        int o_st = m_st;
        logic o_txf = m_txf, o_rxf = m_rxf, take = 0, put = 0, be = 0, ee = 0;
        logic [7:0] o_txb = m_txb, pv = 0;
        if (halt && o_st != 0) begin
            put = 1; pv = m_sreg; m_st = 0;
        end else if (o_st == 0) begin
            if (!halt && (dir_tx ? o_txf : 1'b1)) begin
                m_sreg = o_txb; m_t = 0; m_st = 1;
                if (dir_tx) begin take = 1; be = 1; end
            end
        end else if (o_st == 1) begin
            if (m_t % D == D - 1) begin
                if ((m_t / D) % 2 == 0) m_smp = sd_in;
                else m_sreg = {m_sreg[6:0], m_smp};
            end
            if (m_t == TEL - 1) begin
                ee = 1;
                if (dir_tx || !o_rxf) begin
                    put = 1; pv = m_sreg; m_st = 0;
                    if (!dir_tx) be = 1;
                end else m_st = 2;
            end else m_t++;
        end else begin
            if (!o_rxf) begin put = 1; pv = m_sreg; be = !dir_tx; m_st = 0; end
        end
        if (take) m_txf = 0;
        if (tx_wr) begin m_txb = tx_din; m_txf = 1; end
        if (rx_rd) m_rxf = 0;
        if (put) begin m_rxb = pv; m_rxf = 1; end
        m_irq = irq_en && (irq_on_end ? ee : be);
    endtask

    task automatic compare();
        logic e_sc = (m_st == 1) ? (((m_t / D) % 2 == 1) ^ edge_sel) : !edge_sel;
        logic e_sd = (m_st == 1) ? m_sreg[7] : 1'b1;
        check(sc === e_sc, "R3/R11 sc", sc, e_sc);
        check(sd_out === e_sd, "R2 sd_out", sd_out, e_sd);
        check(sd_oe === (three_wire ? 1'b1 : dir_tx), "R10 sd_oe", sd_oe, three_wire ? 1 : dir_tx);
        check(ready === (dir_tx ? m_txf : m_rxf), "R4/R5 ready", ready, dir_tx ? m_txf : m_rxf);
        check(active === (m_st == 1), "R8 active", active, m_st == 1);
        check(irq === m_irq, "R9 irq", irq, m_irq);
        check(rx_data === m_rxb, "R5/R6/R7 rx_data", rx_data, m_rxb);
        if (irq) irq_cnt++;
    endtask

    task automatic tick();
        if (loop) sd_in = sd_out;
        else begin pat = {pat[6:0], pat[7] ^ pat[5]}; sd_in = pat[0]; end
        model_step();
        @(negedge clk);
        cyc++;
        compare();
        tx_wr = 0; rx_rd = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sc === 1'b1, "R1 sc idle", sc, 1);
        check(active === 0 && ready === 0 && irq === 0, "R1 flags", {active, ready, irq}, 0);
        check(sd_out === 1 && rx_data === 0, "R1 data", {sd_out, rx_data}, 9'h100);
        rst_n = 1;

        // R2/R9: transmit with loopback, buffer-status interrupt
        loop = 1; tx_wr = 1; tx_din = 8'hA5;
        tick();
        halt = 0; irq_cnt = 0;
        tick();                                   // telegram start
        tx_wr = 1; tx_din = 8'h3C;
        ticks(TEL);
        check(rx_data === 8'hA5, "R2 loopback word 1", rx_data, 8'hA5);
        ticks(TEL + 1);
        check(rx_data === 8'h3C, "R2 loopback word 2", rx_data, 8'h3C);
        check(irq_cnt == 2, "R9 buffer irq count", irq_cnt, 2);

        // R4: empty transmit buffer stalls
        ticks(30);
        check(active === 0 && sc === 1, "R4 stall idle", {active, sc}, 2'b01);
        check(ready === 0, "R4 ready empty", ready, 0);

        // R3/R10/R9: other edge, two-wire, end-of-telegram interrupt
        halt = 1; tick();
        edge_sel = 1; three_wire = 0; irq_on_end = 1; irq_cnt = 0;
        tick();
        check(sd_oe === 1, "R10 two-wire tx oe", sd_oe, 1);
        check(sc === 0, "R3 idle low", sc, 0);
        tx_wr = 1; tx_din = 8'h96; halt = 0;
        ticks(TEL + 5);
        check(rx_data === 8'h96, "R3 loopback edge1", rx_data, 8'h96);
        check(irq_cnt == 1, "R9 end irq count", irq_cnt, 1);

        // R5/R6: receive mode, words left unread
        halt = 1; tick();
        loop = 0; dir_tx = 0; edge_sel = 0; irq_on_end = 0; rx_rd = 1;
        tick();
        check(sd_oe === 0, "R10 two-wire rx oe", sd_oe, 0);
        halt = 0; tick();
        check(active === 1, "R5 rx starts at once", active, 1);
        ticks(3 * TEL + 10);
        check(active === 0 && ready === 1, "R6 stalled on full", {active, ready}, 2'b01);
        rx_rd = 1; ticks(3);
        check(ready === 1, "R6 held word moved", ready, 1);
        ticks(TEL);

        // R7: halt after three bits
        halt = 1; tick();
        dir_tx = 1; tx_wr = 1; tx_din = 8'h00; tick();
        dir_tx = 0; rx_rd = 1; tick();
        loop = 1; halt = 0;
        tick();
        loop = 0;
        for (int i = 0; i < 6 * D; i++) begin
            sd_in = 1'b1; model_step(); @(negedge clk); cyc++; compare();
        end
        halt = 1; sd_in = 1'b1; model_step(); @(negedge clk); cyc++; compare();
        check(rx_data === 8'h07, "R7 partial word", rx_data, 8'h07);
        check(active === 0 && sc === 1, "R7 clock stopped", {active, sc}, 2'b01);
        check(ready === 1, "R7 buffer full", ready, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule